// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned N-bit integer by another over several clock cycles. A caller presents the two operands with a start strobe while the unit is idle. The unit then produces one quotient bit per cycle. It uses a single double-width working register: the upper half holds the running partial remainder and the lower half holds the dividend bits still to be consumed, which are replaced step by step by the quotient bits.

Each step shifts the working register one place left. It then tries to subtract the divisor from the upper part. If the trial does not go below zero, the difference is kept and a one enters the quotient. If it goes below zero, the shifted value is kept unchanged and a zero enters the quotient. After N steps the quotient and remainder are copied to the output registers and a one-cycle completion strobe is raised. A zero divisor is detected when the operands are accepted and answered at once with an error flag.

Top module: `restoring_divider`

## Requirements
- R1: A start strobe seen at a rising edge while busy is low is accepted and captures both operands. For a non-zero divisor, busy reads high from the cycle after the accepting edge until the result is ready.
- R2: For a non-zero divisor, done is high in the cycle that follows the WIDTH-th rising edge after the accepting edge, and busy is low in that cycle.
- R3: For a non-zero divisor, the quotient equals the integer part of dividend/divisor and the remainder equals dividend minus quotient times divisor, which is always smaller than the divisor. Both are unsigned.
- R4: Done stays high for exactly one cycle per accepted operation.
- R5: A zero divisor gives the following outcome. The error flag is 1, the quotient is all ones and the remainder equals the dividend. Done is high in the cycle right after the accepting edge, and busy never rises.
- R6: A start strobe raised while busy is high is ignored. The running result and its latency do not change.
- R7: The quotient, the remainder and the error flag change only at the edge that raises done. They hold their values until the next completion, and the error flag is 0 after any non-zero-divisor completion.
- R8: While reset is high and after it is released, busy, done and the error flag are 0, and the quotient and remainder are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a division |
| dividend_i | input | WIDTH | Unsigned dividend, sampled on acceptance |
| divisor_i | input | WIDTH | Unsigned divisor, sampled on acceptance |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion strobe |
| quotient_o | output | WIDTH | Registered quotient |
| remainder_o | output | WIDTH | Registered remainder |
| div_zero_o | output | 1 | Last completion had a zero divisor |

## Verification
The bench builds the divider with WIDTH set to 8. At that width, the extreme operands can all be driven directly: a dividend of 255, a divisor of 1, equal operands, a dividend smaller than the divisor, and a full sweep of every divisor against a fixed dividend. The short latency also lets the bench count cycles exactly. It can inject a start strobe in the middle of a run and then confirm that the first operation's result and timing are unchanged.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;

endpackage

// File: rtl/rdiv_step.sv
// One shift / trial-subtract / restore iteration on the working register.
module rdiv_step #(
  parameter int WIDTH = 16
) (
  input  logic [2*WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0]   divisor_i,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int TW = WIDTH + 1;

  logic [TW-1:0] shifted_hi;
  logic [TW-1:0] trial;
  logic          negative;

  // Upper half after the left shift keeps the bit that leaves the top.
  assign shifted_hi = acc_i[2*WIDTH-1:WIDTH-1];
  assign trial      = shifted_hi - {1'b0, divisor_i};
  assign negative   = trial[TW-1];

  always_comb begin
    if (negative) begin
      // Restore: keep the shifted partial remainder, quotient bit 0.
      acc_o = {shifted_hi[WIDTH-1:0], acc_i[WIDTH-2:0], 1'b0};
    end else begin
      acc_o = {trial[WIDTH-1:0], acc_i[WIDTH-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/rdiv_ctrl.sv
// Sequencer: accepts a request, counts WIDTH iterations, flags the last one.
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_div_i,
  output logic load_o,
  output logic zero_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  rdiv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && !zero_div_i;
  assign zero_o = accept && zero_div_i;
  assign step_o = (state_q == ST_RUN);
  assign last_o = step_o && (cnt_q == LAST_CNT);
  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);
  localparam int ACC_W = 2 * WIDTH;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic [WIDTH-1:0] dvr_q;
  logic             load, zero_req, step, last;
  logic             zero_div;

  assign zero_div = (divisor_i == '0);

  rdiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .zero_div_i(zero_div),
    .load_o    (load),
    .zero_o    (zero_req),
    .step_o    (step),
    .last_o    (last),
    .busy_o    (busy_o)
  );

  rdiv_step #(.WIDTH(WIDTH)) step_i (
    .acc_i    (acc_q),
    .divisor_i(dvr_q),
    .acc_o    (acc_next)
  );

  // Working register: remainder on the left, dividend/quotient on the right.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      dvr_q <= '0;
    end else if (load) begin
      acc_q <= {{WIDTH{1'b0}}, dividend_i};
      dvr_q <= divisor_i;
    end else if (step) begin
      acc_q <= acc_next;
    end
  end

  // Result registers written only on completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
    end else if (last) begin
      done_o      <= 1'b1;
      quotient_o  <= acc_next[WIDTH-1:0];
      remainder_o <= acc_next[ACC_W-1:WIDTH];
      div_zero_o  <= 1'b0;
    end else if (zero_req) begin
      done_o      <= 1'b1;
      quotient_o  <= '1;
      remainder_o <= dividend_i;
      div_zero_o  <= 1'b1;
    end else begin
      done_o      <= 1'b0;
    end
  end

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             div_zero_o
);
  typedef logic [2*WIDTH-1:0] wide_t;

  logic [WIDTH-1:0] cap_dnd, cap_dvr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dnd <= '0;
      cap_dvr <= '0;
    end else if (start_i && !busy_o) begin
      cap_dnd <= dividend_i;
      cap_dvr <= divisor_i;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o || done_o));

  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_result_identity_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !div_zero_o) |->
      ((wide_t'(quotient_o) * wide_t'(cap_dvr) + wide_t'(remainder_o)) == wide_t'(cap_dnd))
      && (remainder_o < cap_dvr));

  assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && div_zero_o) |-> (quotient_o == '1) && (remainder_o == cap_dnd)
      && (cap_dvr == '0));

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

endmodule

bind restoring_divider restoring_divider_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .div_zero_o (div_zero_o)
);

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int checks = 0;
  int errors = 0;
  logic [2*W:0] exp_q[$];
  logic [2*W:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  restoring_divider #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == '0) return {1'b1, {W{1'b1}}, a};
    return {1'b0, W'(a / b), W'(a % b)};
  endfunction

  // Monitor: compare each completion against the scoreboard.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      logic [2*W:0] e;
      if (exp_q.size() == 0) begin
        check("R4 unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check("R3/R5 error flag", div_zero_o, e[2*W]);
        check("R3/R5 quotient", quotient_o, e[2*W-1:W]);
        check("R3/R5 remainder", remainder_o, e[W-1:0]);
      end
    end
  end

  // Driver: push expectation, strobe start, measure latency and pulse width.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int lat;
    last_exp = model(a, b);
    exp_q.push_back(last_exp);
    @(negedge clk);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    if (b != '0) check("R1 busy after accept", busy_o, 1);
    else check("R5 no busy on zero divisor", busy_o, 0);
    while (!done_o) begin
      if (poke && lat == 2) begin
        // R6: foreign request during the run
        dividend_i = ~a; divisor_i = 8'd3; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    if (b != '0) check(poke ? "R6 latency with ignored start" : "R2 latency", lat, W);
    else check("R5 latency", lat, 0);
    check("R2 busy low at done", busy_o, 0);
    @(negedge clk);
    check("R4 done single cycle", done_o, 0);
    check("R7 quotient held", quotient_o, last_exp[2*W-1:W]);
    check("R7 remainder held", remainder_o, last_exp[W-1:0]);
    check("R7 flag held", div_zero_o, last_exp[2*W]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 busy in reset", busy_o, 0);
    check("R8 done in reset", done_o, 0);
    check("R8 quotient in reset", quotient_o, 0);
    check("R8 remainder in reset", remainder_o, 0);
    check("R8 flag in reset", div_zero_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", {busy_o, done_o, div_zero_o}, 0);

    run_div(8'd100, 8'd7, 0);
    run_div(8'd255, 8'd1, 0);
    run_div(8'd0, 8'd5, 0);
    run_div(8'd5, 8'd9, 0);
    run_div(8'd255, 8'd255, 0);
    run_div(8'd128, 8'd128, 0);
    run_div(8'd200, 8'd0, 0);   // R5
    run_div(8'd77, 8'd10, 0);   // R7 flag clears after zero case
    run_div(8'd0, 8'd0, 0);     // R5
    run_div(8'd199, 8'd13, 1);  // R6
    for (int d = 1; d < 256; d++) run_div(8'd255, W'(d), 0);
    for (int n = 0; n < 256; n += 17) run_div(W'(n), 8'd128, 0);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule